// File: doc/BRIEF.md
# Translating Bus Address Decoder

This block joins one Wishbone B4 initiator port to a fixed set of subordinate ports. It is purely combinational. Each subordinate owns an aligned address window whose base is set by a parameter and counted in units of the decoder's granularity. The decoder finds the window that holds the initiator's word address and raises cycle only toward that subordinate. It hands the subordinate the word offset inside its window. It then steers that subordinate's read data and handshake back to the initiator.

Subordinates may differ from the decoder in two ways. A dense subordinate has the decoder's data width and a granularity that is finer or equal, so each initiator select bit fans out to several subordinate select bits. A sparse subordinate has a data width equal to its granularity. It sits in lane 0 of each decoder word: it sees only select bit 0, and its narrow read data returns zero-extended. Each subordinate may or may not have the optional error, retry and stall responses. The decoder fills in a neutral value for any response a subordinate lacks.

Top module: `wb_xlat_decoder`

## Requirements
- R1: At most one bit of `sub_cyc_o` is high, and a bit is high only when `cyc_i` is high and the word address lies in that subordinate's window. If windows overlap, the lowest index wins.
- R2: `sub_stb_o`, `sub_we_o`, `sub_lock_o`, `sub_dat_o`, `sub_cti_o` and `sub_bte_o` equal the matching initiator inputs at all times, whichever subordinate is selected.
- R3: Each subordinate's field of `sub_adr_o` (field k = bits k*ADDR_W upward) carries the low `SUB_AW[k]` bits of `adr_i`, which is the word offset from the window base. The upper bits of the field are zero.
- R4: While `cyc_i` is low, `sub_cyc_o` is all zero, and `ack_o`, `err_o`, `rty_o`, `stall_o` and `dat_o` are all zero.
- R5: While `cyc_i` is high and no window matches, `sub_cyc_o` is all zero and every response output including `dat_o` is zero.
- R6: `ack_o`, `err_o`, `rty_o`, `stall_o` and `dat_o` come only from the selected subordinate. Responses of the other subordinates have no effect.
- R7: For a subordinate built without error or retry support, `err_o` or `rty_o` reads 0 even when its `sub_err_i` or `sub_rty_i` input is high.
- R8: For a subordinate built without stall support, `stall_o` equals the inverse of its `sub_ack_i`.
- R9: For a dense subordinate with granularity g, initiator select bit i drives subordinate select bits i*(GRAN/g) through i*(GRAN/g)+GRAN/g-1. Unused upper bits of its `sub_sel_o` field (SSEL_W bits per subordinate) are zero.
- R10: For a sparse subordinate, bit 0 of its `sub_sel_o` field equals `sel_i[0]` and all other bits are zero.
- R11: For a sparse subordinate of width w, `dat_o` equals the low w bits of its `sub_dat_i` field zero-extended. Its upper input bits are ignored.
- R12: A window of a subordinate with `SUB_AW` address bits covers exactly 2^SUB_AW decoder words from base/(DATA_W/GRAN). The last word matches and the word after it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cyc_i | input | 1 | Initiator bus cycle |
| stb_i | input | 1 | Initiator strobe |
| we_i | input | 1 | Initiator write enable |
| lock_i | input | 1 | Initiator lock |
| adr_i | input | ADDR_W | Initiator word address |
| sel_i | input | DATA_W/GRAN | Initiator byte-lane select |
| dat_i | input | DATA_W | Initiator write data |
| cti_i | input | 3 | Cycle type |
| bte_i | input | 2 | Burst type |
| dat_o | output | DATA_W | Read data to initiator |
| ack_o | output | 1 | Acknowledge to initiator |
| err_o | output | 1 | Error to initiator |
| rty_o | output | 1 | Retry to initiator |
| stall_o | output | 1 | Stall to initiator |
| sub_cyc_o | output | N_SUB | Per-subordinate cycle |
| sub_stb_o | output | 1 | Shared strobe |
| sub_we_o | output | 1 | Shared write enable |
| sub_lock_o | output | 1 | Shared lock |
| sub_adr_o | output | N_SUB*ADDR_W | Per-subordinate window offset |
| sub_sel_o | output | N_SUB*SSEL_W | Per-subordinate select |
| sub_dat_o | output | DATA_W | Shared write data |
| sub_cti_o | output | 3 | Shared cycle type |
| sub_bte_o | output | 2 | Shared burst type |
| sub_dat_i | input | N_SUB*DATA_W | Per-subordinate read data |
| sub_ack_i | input | N_SUB | Per-subordinate acknowledge |
| sub_err_i | input | N_SUB | Per-subordinate error |
| sub_rty_i | input | N_SUB | Per-subordinate retry |
| sub_stall_i | input | N_SUB | Per-subordinate stall |

## Verification
The bench uses the default parameters: a 32-bit, 16-bit-granular decoder with a 19-bit word address and four windows. Two windows are dense, one at the decoder's granularity and one at byte granularity. Two are sparse, 16 and 8 bits wide. The error, retry and stall options are mixed across them. This single build reaches select fan-out by one and by two, both sparse widths, every filled-in response, and the word on either side of a window edge. Misses both below all windows and in the gaps between them are also covered.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;
  localparam int unsigned CTI_W = 3;
  localparam int unsigned BTE_W = 2;

  typedef struct packed {
    logic ack;
    logic err;
    logic rty;
    logic stall;
  } wbdec_rsp_t;
endpackage

// File: rtl/wbdec_window.sv
module wbdec_window #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned WIN_AW    = 7,
  parameter int unsigned BASE_WORD = 0
) (
  input  logic [ADDR_W-1:0] adr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] MASK   = (ADDR_W'(1) << WIN_AW) - ADDR_W'(1);

  // base is aligned to the window, so compare only the bits above it
  assign hit_o = (adr_i >> WIN_AW) == (BASE_V >> WIN_AW);
  assign off_o = adr_i & MASK;
endmodule

// File: rtl/wbdec_lane.sv
module wbdec_lane
  import wbdec_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned GRAN      = 16,
  parameter int unsigned MIN_GRAN  = 8,
  parameter int unsigned SUB_GRAN  = 16,
  parameter int unsigned SUB_DW    = 32,
  parameter bit          SPARSE    = 1'b0,
  parameter bit          HAS_ERR   = 1'b1,
  parameter bit          HAS_RTY   = 1'b1,
  parameter bit          HAS_STALL = 1'b1,
  localparam int unsigned SEL_W    = DATA_W / GRAN,
  localparam int unsigned SSEL_W   = DATA_W / MIN_GRAN
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] sub_dat_i,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic              rty_i,
  input  logic              stall_i,
  output logic [SSEL_W-1:0] sub_sel_o,
  output logic [DATA_W-1:0] rdat_o,
  output wbdec_rsp_t        rsp_o
);
  logic unused_lane;
  assign unused_lane = ^{sel_i, sub_dat_i, err_i, rty_i, stall_i};

  if (SPARSE) begin : g_sparse
    assign sub_sel_o = SSEL_W'(sel_i[0]);
    assign rdat_o    = DATA_W'(sub_dat_i[SUB_DW-1:0]);
  end else begin : g_dense
    localparam int unsigned REP = GRAN / SUB_GRAN;
    logic [SEL_W*REP-1:0] sel_x;
    for (genvar i = 0; i < SEL_W; i++) begin : g_lane
      for (genvar j = 0; j < REP; j++) begin : g_rep
        assign sel_x[i*REP+j] = sel_i[i];
      end
    end
    assign sub_sel_o = SSEL_W'(sel_x);
    assign rdat_o    = sub_dat_i;
  end

  assign rsp_o.ack   = ack_i;
  assign rsp_o.err   = HAS_ERR ? err_i : 1'b0;
  assign rsp_o.rty   = HAS_RTY ? rty_i : 1'b0;
  // classic subordinate: holds the initiator until it acknowledges
  assign rsp_o.stall = HAS_STALL ? stall_i : ~ack_i;
endmodule

// File: rtl/wb_xlat_decoder.sv
module wb_xlat_decoder
  import wbdec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GRAN     = 16,
  parameter int unsigned MIN_GRAN = 8,
  parameter int unsigned N_SUB    = 4,
  parameter int unsigned SUB_BASE  [N_SUB] = '{32'h10000, 32'h20000, 32'h30000, 32'h40000},
  parameter int unsigned SUB_AW    [N_SUB] = '{7, 6, 8, 8},
  parameter int unsigned SUB_GRAN  [N_SUB] = '{16, 8, 16, 8},
  parameter int unsigned SUB_DW    [N_SUB] = '{32, 32, 16, 8},
  parameter bit          SUB_SPARSE[N_SUB] = '{1'b0, 1'b0, 1'b1, 1'b1},
  parameter bit          SUB_ERR   [N_SUB] = '{1'b1, 1'b0, 1'b1, 1'b0},
  parameter bit          SUB_RTY   [N_SUB] = '{1'b1, 1'b0, 1'b0, 1'b0},
  parameter bit          SUB_STALL [N_SUB] = '{1'b1, 1'b0, 1'b0, 1'b0},
  localparam int unsigned SEL_W  = DATA_W / GRAN,
  localparam int unsigned SSEL_W = DATA_W / MIN_GRAN
) (
  input  logic                     cyc_i,
  input  logic                     stb_i,
  input  logic                     we_i,
  input  logic                     lock_i,
  input  logic [ADDR_W-1:0]        adr_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [DATA_W-1:0]        dat_i,
  input  logic [CTI_W-1:0]         cti_i,
  input  logic [BTE_W-1:0]         bte_i,
  output logic [DATA_W-1:0]        dat_o,
  output logic                     ack_o,
  output logic                     err_o,
  output logic                     rty_o,
  output logic                     stall_o,
  output logic [N_SUB-1:0]         sub_cyc_o,
  output logic                     sub_stb_o,
  output logic                     sub_we_o,
  output logic                     sub_lock_o,
  output logic [N_SUB*ADDR_W-1:0]  sub_adr_o,
  output logic [N_SUB*SSEL_W-1:0]  sub_sel_o,
  output logic [DATA_W-1:0]        sub_dat_o,
  output logic [CTI_W-1:0]         sub_cti_o,
  output logic [BTE_W-1:0]         sub_bte_o,
  input  logic [N_SUB*DATA_W-1:0]  sub_dat_i,
  input  logic [N_SUB-1:0]         sub_ack_i,
  input  logic [N_SUB-1:0]         sub_err_i,
  input  logic [N_SUB-1:0]         sub_rty_i,
  input  logic [N_SUB-1:0]         sub_stall_i
);
  logic [N_SUB-1:0]  hit;
  logic [N_SUB-1:0]  pick;
  logic [DATA_W-1:0] rdat  [N_SUB];
  wbdec_rsp_t        rsp_v [N_SUB];
  wbdec_rsp_t        rsp;

  assign sub_stb_o  = stb_i;
  assign sub_we_o   = we_i;
  assign sub_lock_o = lock_i;
  assign sub_dat_o  = dat_i;
  assign sub_cti_o  = cti_i;
  assign sub_bte_o  = bte_i;

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    localparam int unsigned BASE_WORD = SUB_BASE[g] / SEL_W;

    wbdec_window #(
      .ADDR_W   (ADDR_W),
      .WIN_AW   (SUB_AW[g]),
      .BASE_WORD(BASE_WORD)
    ) i_window (
      .adr_i(adr_i),
      .hit_o(hit[g]),
      .off_o(sub_adr_o[g*ADDR_W +: ADDR_W])
    );

    wbdec_lane #(
      .DATA_W   (DATA_W),
      .GRAN     (GRAN),
      .MIN_GRAN (MIN_GRAN),
      .SUB_GRAN (SUB_GRAN[g]),
      .SUB_DW   (SUB_DW[g]),
      .SPARSE   (SUB_SPARSE[g]),
      .HAS_ERR  (SUB_ERR[g]),
      .HAS_RTY  (SUB_RTY[g]),
      .HAS_STALL(SUB_STALL[g])
    ) i_lane (
      .sel_i    (sel_i),
      .sub_dat_i(sub_dat_i[g*DATA_W +: DATA_W]),
      .ack_i    (sub_ack_i[g]),
      .err_i    (sub_err_i[g]),
      .rty_i    (sub_rty_i[g]),
      .stall_i  (sub_stall_i[g]),
      .sub_sel_o(sub_sel_o[g*SSEL_W +: SSEL_W]),
      .rdat_o   (rdat[g]),
      .rsp_o    (rsp_v[g])
    );
  end

  // lowest index wins if windows overlap
  always_comb begin
    logic taken;
    pick  = '0;
    taken = 1'b0;
    for (int k = 0; k < N_SUB; k++) begin
      if (hit[k] && !taken) begin
        pick[k] = 1'b1;
        taken   = 1'b1;
      end
    end
  end

  assign sub_cyc_o = cyc_i ? pick : '0;

  always_comb begin
    dat_o = '0;
    rsp   = '0;
    for (int k = 0; k < N_SUB; k++) begin
      if (sub_cyc_o[k]) begin
        dat_o = dat_o | rdat[k];
        rsp   = wbdec_rsp_t'(rsp | rsp_v[k]);
      end
    end
  end

  assign ack_o   = rsp.ack;
  assign err_o   = rsp.err;
  assign rty_o   = rsp.rty;
  assign stall_o = rsp.stall;
endmodule

// File: rtl/wbdec_chk.sv
module wbdec_chk #(
  parameter int unsigned N_SUB  = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              cyc_i,
  input logic [N_SUB-1:0]  sub_cyc_o,
  input logic [N_SUB-1:0]  sub_ack_i,
  input logic [N_SUB-1:0]  sub_err_i,
  input logic              ack_o,
  input logic              err_o,
  input logic              rty_o,
  input logic              stall_o,
  input logic [DATA_W-1:0] dat_o
);
  always_comb begin
    // R1
    one_cyc_chk: assert ($onehot0(sub_cyc_o))
      else $error("more than one subordinate cycle");
    // R1
    cyc_gate_chk: assert (!(|sub_cyc_o) || cyc_i)
      else $error("subordinate cycle without initiator cycle");
    // R4
    idle_quiet_chk: assert (cyc_i || (!ack_o && !err_o && !rty_o && !stall_o && dat_o == '0))
      else $error("response while initiator idle");
    // R5
    no_target_chk: assert (!cyc_i || (|sub_cyc_o) || (!ack_o && !err_o && dat_o == '0))
      else $error("response with no selected subordinate");
    // R6
    ack_src_chk: assert (!ack_o || (|(sub_cyc_o & sub_ack_i)))
      else $error("ack not from selected subordinate");
    // R6
    err_src_chk: assert (!err_o || (|(sub_cyc_o & sub_err_i)))
      else $error("err not from selected subordinate");
  end
endmodule

bind wb_xlat_decoder wbdec_chk #(
  .N_SUB (N_SUB),
  .DATA_W(DATA_W)
) i_wbdec_chk (
  .cyc_i    (cyc_i),
  .sub_cyc_o(sub_cyc_o),
  .sub_ack_i(sub_ack_i),
  .sub_err_i(sub_err_i),
  .ack_o    (ack_o),
  .err_o    (err_o),
  .rty_o    (rty_o),
  .stall_o  (stall_o),
  .dat_o    (dat_o)
);

// File: tb/test_wb_xlat_decoder.sv
module test_wb_xlat_decoder;
  localparam int AW = 19;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int SW = 4;

  typedef struct {
    int          idx;
    logic [3:0]  cyc;
    logic [31:0] dat;
    logic [3:0]  rsp;
    logic [18:0] sadr;
    logic [3:0]  ssel;
    logic [31:0] wdat;
    logic [5:0]  bc;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          cyc_i = 0, stb_i = 0, we_i = 0, lock_i = 0;
  logic [AW-1:0] adr_i = '0;
  logic [1:0]    sel_i = '0;
  logic [DW-1:0] dat_i = '0;
  logic [2:0]    cti_i = '0;
  logic [1:0]    bte_i = '0;
  logic [DW-1:0] dat_o;
  logic          ack_o, err_o, rty_o, stall_o;
  logic [NS-1:0] sub_cyc_o;
  logic          sub_stb_o, sub_we_o, sub_lock_o;
  logic [NS*AW-1:0] sub_adr_o;
  logic [NS*SW-1:0] sub_sel_o;
  logic [DW-1:0] sub_dat_o;
  logic [2:0]    sub_cti_o;
  logic [1:0]    sub_bte_o;
  logic [NS*DW-1:0] sub_dat_i = {32'h77778888, 32'h55556666, 32'h33334444, 32'h11112222};
  logic [NS-1:0] sub_ack_i = '0, sub_err_i = '0, sub_rty_i = '0, sub_stall_i = '0;

  wb_xlat_decoder i_wb_xlat_decoder (
    .cyc_i, .stb_i, .we_i, .lock_i, .adr_i, .sel_i, .dat_i, .cti_i, .bte_i,
    .dat_o, .ack_o, .err_o, .rty_o, .stall_o,
    .sub_cyc_o, .sub_stb_o, .sub_we_o, .sub_lock_o, .sub_adr_o, .sub_sel_o,
    .sub_dat_o, .sub_cti_o, .sub_bte_o,
    .sub_dat_i, .sub_ack_i, .sub_err_i, .sub_rty_i, .sub_stall_i
  );

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  int n_drv = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic cyc, input logic [18:0] adr, input logic [1:0] sel,
                       input logic [3:0] ack, input logic [3:0] err, input logic [3:0] rty,
                       input logic [3:0] stl, input int idx, input logic [3:0] ecyc,
                       input logic [31:0] edat, input logic [3:0] ersp,
                       input logic [18:0] esadr, input logic [3:0] essel, input string req);
    item_t it;
    @(negedge clk);
    n_drv++;
    cyc_i = cyc; adr_i = adr; sel_i = sel;
    sub_ack_i = ack; sub_err_i = err; sub_rty_i = rty; sub_stall_i = stl;
    stb_i = n_drv[0]; we_i = n_drv[1]; lock_i = n_drv[2];
    cti_i = 3'(n_drv); bte_i = 2'(n_drv + 1);
    dat_i = 32'hC0DE0000 + 32'(n_drv * 32'h111);
    it.idx = idx; it.cyc = ecyc; it.dat = edat; it.rsp = ersp;
    it.sadr = esadr; it.ssel = essel; it.req = req;
    it.wdat = dat_i;
    it.bc = {stb_i, we_i, lock_i, cti_i};
    q.push_back(it);
  endtask

  // monitor: inputs change at negedge, compare at posedge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({it.req, "/R1"}, "sub_cyc", 32'(sub_cyc_o), 32'(it.cyc));
      chk(it.req, "dat_o", dat_o, it.dat);
      chk(it.req, "rsp ack,err,rty,stall", 32'({ack_o, err_o, rty_o, stall_o}), 32'(it.rsp));
      chk("R2", "broadcast ctl", 32'({sub_stb_o, sub_we_o, sub_lock_o, sub_cti_o, sub_bte_o}),
          32'({it.bc, 2'(it.bc[2:0] + 3'd1)}));
      chk("R2", "broadcast data", sub_dat_o, it.wdat);
      if (it.idx >= 0) begin
        chk({it.req, "/R3"}, "sub_adr", 32'(sub_adr_o[it.idx*AW +: AW]), 32'(it.sadr));
        chk(it.req, "sub_sel", 32'(sub_sel_o[it.idx*SW +: SW]), 32'(it.ssel));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R4 idle state
    drive(0, 19'h08005, 2'b11, 4'hF, 4'hF, 4'hF, 4'hF, -1, 4'b0000, 32'h0, 4'b0000, 0, 0, "R4 idle");
    // R6 R9 dense, same granularity
    drive(1, 19'h08005, 2'b10, 4'hF, 4'hF, 4'hF, 4'h1, 0, 4'b0001, 32'h11112222, 4'b1111, 19'h05, 4'b0010, "R6 R9 sub0");
    // R12 last word of window, R6 other subs' responses ignored
    drive(1, 19'h0807F, 2'b01, 4'hE, 4'hE, 4'h1, 4'h0, 0, 4'b0001, 32'h11112222, 4'b0010, 19'h7F, 4'b0001, "R12 R6 sub0 edge");
    // R12 word after window
    drive(1, 19'h08080, 2'b11, 4'hF, 4'hF, 4'hF, 4'hF, -1, 4'b0000, 32'h0, 4'b0000, 0, 0, "R12 past sub0");
    // R7 R8 R9 dense, finer granularity
    drive(1, 19'h1002A, 2'b10, 4'hF, 4'hF, 4'hF, 4'hF, 1, 4'b0010, 32'h33334444, 4'b1000, 19'h2A, 4'b1100, "R7 R8 R9 sub1");
    // R8 no ack -> stall
    drive(1, 19'h1002A, 2'b01, 4'hD, 4'hF, 4'hF, 4'h0, 1, 4'b0010, 32'h33334444, 4'b0001, 19'h2A, 4'b0011, "R8 R9 sub1 wait");
    // R10 R11 R7 sparse 16-bit
    drive(1, 19'h180FF, 2'b11, 4'hF, 4'hF, 4'hF, 4'h0, 2, 4'b0100, 32'h00006666, 4'b1100, 19'hFF, 4'b0001, "R10 R11 sub2");
    // R10 only upper select set
    drive(1, 19'h18000, 2'b10, 4'hF, 4'h0, 4'hF, 4'hF, 2, 4'b0100, 32'h00006666, 4'b1000, 19'h00, 4'b0000, "R10 sub2 hi sel");
    // R11 R8 sparse 8-bit, no ack
    drive(1, 19'h20010, 2'b01, 4'h7, 4'hF, 4'hF, 4'hF, 3, 4'b1000, 32'h00000088, 4'b0001, 19'h10, 4'b0001, "R11 R8 sub3");
    // R5 below all windows
    drive(1, 19'h00100, 2'b11, 4'hF, 4'hF, 4'hF, 4'hF, -1, 4'b0000, 32'h0, 4'b0000, 0, 0, "R5 miss low");
    // R12 R5 just past sparse windows
    drive(1, 19'h18100, 2'b11, 4'hF, 4'hF, 4'hF, 4'hF, -1, 4'b0000, 32'h0, 4'b0000, 0, 0, "R12 past sub2");
    drive(1, 19'h20100, 2'b11, 4'hF, 4'hF, 4'hF, 4'hF, -1, 4'b0000, 32'h0, 4'b0000, 0, 0, "R12 past sub3");
    // R4 idle inside a window
    drive(0, 19'h1002A, 2'b11, 4'hF, 4'hF, 4'hF, 4'hF, -1, 4'b0000, 32'h0, 4'b0000, 0, 0, "R4 idle in window");
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule